// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked user port and an asynchronous static RAM with a 19-bit address and a 16-bit data word. It takes one word per request, either read or write, and produces the active-low chip, output and write strobes. It also drives the address and runs the shared data bus through separate out, in and drive-enable signals. Every timing figure of the memory's speed grade is a picosecond parameter. Each one is turned into a whole number of clock cycles by ceiling division, with a floor of one cycle.

Writes are timed by the write-enable pulse, and output enable stays high for the whole write. After write enable falls, the controller leaves the bus undriven until the memory's output float time has passed. It then drives the data, lets write enable rise while the data is still driven, and releases the bus afterwards.

A read holds output enable low for the longest of three limits: the address access time, the output-enable access time and the cycle time. It then samples the bus and shows the word for one clock. A read that directly follows a write first waits out the memory's low-impedance recovery time, with output enable still high.

Top module: `asram_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied and in the first cycle after it, all three strobes are 1, the bus drive enable is 0, ready is 1 and the read-valid pulse is 0.
- R2: A request is taken only in a cycle where ready is 1 and the request line is 1. Ready is 0 from the cycle after acceptance until the operation ends. A request presented while ready is 0 is ignored and changes neither the memory contents nor the strobe sequence.
- R3: Strobe encoding is kept at all times. Chip enable at 1 implies output enable at 1, write enable at 1 and no bus drive. Output enable and write enable are never 0 together. The controller never drives the bus while output enable is 0.
- R4: A write runs as follows. There is 1 cycle with chip enable 0 and the other two strobes at 1. Next come F cycles with write enable 0 and the bus undriven, where F = max(ceil(tWHZ), ceil(tOHZ), 1). Then come D cycles with write enable 0 and the bus driven, where D = max(ceil(tDW), ceil(tWP) − F, 1). Last come H cycles with write enable 1 and the bus still driven, where H = max(1, ceil(tRC) − 1 − F − D).
- R5: A read holds chip enable and output enable at 0 for A = max(ceil(tAA), ceil(tOE), ceil(tRC), 1) cycles. In the first cycle after that, read-valid is 1 for exactly one cycle, and the read data equals the word last written to that address, or 0 if the address was never written.
- R6: A read whose previous operation was a write first spends R = max(1, ceil(tWLZ)) cycles with chip enable 0 and output enable 1 before output enable falls.
- R7: The memory address holds steady for the whole of an operation, and the write data holds steady for as long as it is driven.
- R8: Every operation keeps chip enable 0 for at least ceil(tRC) consecutive cycles.
- R9: While idle (ready at 1), chip enable, output enable and write enable are all 1 and the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| ready | output | 1 | Controller idle, can accept a request |
| rdData | output | 16 | Registered read data |
| rdValid | output | 1 | One-cycle pulse marking rdData |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | 19 | Memory address |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 1 | Bus drive enable for memDqOut |
| memDqIn | input | 16 | Data read from the memory bus |

## Verification
The assertions watch the strobe legality rules on every cycle:
- output enable and write enable are never active together;
- the bus is never driven while output enable is low;
- the drive turns on only after write enable has been low for a cycle and is still on when write enable rises;
- address and write data stay steady within an operation;
- read-valid never lasts two cycles.

Only the bench's scenarios can show the exact length of each phase and the recovery wait before a read that follows a write. They also show that a request arriving while busy leaves memory untouched, and that read data matches what was written across the address range and the data patterns.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WADDR, S_WFLOAT, S_WDRIVE, S_WHOLD, S_RREC, S_RACC
  } ctrlState_t;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  function automatic int cyclesFor(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int FLOAT_CYC = 1,
  parameter int DRIVE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int REC_CYC   = 1,
  parameter int ACC_CYC   = 2,
  parameter int CNT_W     = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    ready,
  output strobe_t strb
);

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic lastWr;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      lastWr <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          lastWr <= reqWrite;
          if (reqWrite) begin
            state <= S_WADDR;
          end else if (lastWr) begin
            state <= S_RREC;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else begin
            state <= S_RACC;
            cnt   <= CNT_W'(ACC_CYC - 1);
          end
        end
        S_WADDR: begin
          state <= S_WFLOAT;
          cnt   <= CNT_W'(FLOAT_CYC - 1);
        end
        S_WFLOAT: if (cntDone) begin
          state <= S_WDRIVE;
          cnt   <= CNT_W'(DRIVE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WDRIVE: if (cntDone) begin
          state <= S_WHOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WHOLD: if (cntDone) state <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        S_RREC: if (cntDone) begin
          state <= S_RACC;
          cnt   <= CNT_W'(ACC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_RACC: if (cntDone) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0, load: 1'b0, capture: 1'b0};
    ready = (state == S_IDLE);
    case (state)
      S_IDLE:   strb.load = reqValid;
      S_WADDR:  strb.ceN = 1'b0;
      S_WFLOAT: begin strb.ceN = 1'b0; strb.weN = 1'b0; end
      S_WDRIVE: begin strb.ceN = 1'b0; strb.weN = 1'b0; strb.drive = 1'b1; end
      S_WHOLD:  begin strb.ceN = 1'b0; strb.drive = 1'b1; end
      S_RREC:   strb.ceN = 1'b0;
      S_RACC:   begin strb.ceN = 1'b0; strb.oeN = 1'b0; strb.capture = cntDone; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      dataQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (strb.capture) rdData <= memDqIn;
    end
  end

  assign memCeN   = strb.ceN;
  assign memOeN   = strb.oeN;
  assign memWeN   = strb.weN;
  assign memDqOe  = strb.drive;
  assign memAddr  = addrQ;
  assign memDqOut = dataQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OE_PS   = 4000,
  parameter int T_WP_PS   = 7000,
  parameter int T_DW_PS   = 5000,
  parameter int T_WHZ_PS  = 4000,
  parameter int T_OHZ_PS  = 4000,
  parameter int T_WLZ_PS  = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RC_CYC    = cyclesFor(T_RC_PS, CLK_PS);
  localparam int FLOAT_CYC = maxOf(cyclesFor(T_WHZ_PS, CLK_PS), cyclesFor(T_OHZ_PS, CLK_PS));
  localparam int DRIVE_CYC = maxOf(cyclesFor(T_DW_PS, CLK_PS),
                                   maxOf(cyclesFor(T_WP_PS, CLK_PS) - FLOAT_CYC, 1));
  localparam int HOLD_CYC  = maxOf(1, RC_CYC - 1 - FLOAT_CYC - DRIVE_CYC);
  localparam int REC_CYC   = cyclesFor(T_WLZ_PS, CLK_PS);
  localparam int ACC_CYC   = maxOf(RC_CYC, maxOf(cyclesFor(T_AA_PS, CLK_PS),
                                                 cyclesFor(T_OE_PS, CLK_PS)));
  localparam int MAX_CYC   = maxOf(maxOf(FLOAT_CYC, DRIVE_CYC),
                                   maxOf(maxOf(HOLD_CYC, REC_CYC), ACC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  strobe_t strb;

  asram_fsm #(
    .FLOAT_CYC(FLOAT_CYC), .DRIVE_CYC(DRIVE_CYC), .HOLD_CYC(HOLD_CYC),
    .REC_CYC(REC_CYC), .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
  ) uFsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .strb(strb)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .rdData(rdData), .rdValid(rdValid),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              ready,
  input logic              rdValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(!memOeN && !memWeN));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    memCeN |-> (memOeN && memWeN && !memDqOe));

  assert_no_contention_R3: assert property (@(posedge clk) disable iff (rst)
    !(memDqOe && !memOeN));

  assert_float_before_drive_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memDqOe) |-> (!memWeN && $past(!memWeN) && $past(!memDqOe)));

  assert_data_held_at_we_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> memDqOe);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |-> $stable(memAddr));

  assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

  assert_busy_from_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(reqValid));

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> (memCeN && !memDqOe));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .ready(ready), .rdValid(rdValid),
  .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
  .memDqOut(memDqOut), .memDqOe(memDqOe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int CLK_PS = 5000;
  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RC = cyc(10000);
  localparam int F  = mx(cyc(4000), cyc(4000));
  localparam int D  = mx(cyc(5000), mx(cyc(7000) - F, 1));
  localparam int H  = mx(1, RC - 1 - F - D);
  localparam int R  = cyc(3000);
  localparam int A  = mx(mx(cyc(10000), cyc(4000)), RC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic ready, rdValid, memCeN, memOeN, memWeN, memDqOe;
  logic [15:0] rdData, memDqOut;
  logic [15:0] memDqIn;
  logic [18:0] memAddr;

  always #2.5 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdData(rdData),
    .rdValid(rdValid), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural memory device
  logic [15:0] ramArr [logic [18:0]];
  always @(posedge memWeN)
    if (memCeN === 1'b0 && memDqOe === 1'b1) ramArr[memAddr] = memDqOut;
  always @* begin
    if (memCeN === 1'b0 && memOeN === 1'b0 && memWeN === 1'b1)
      memDqIn = ramArr.exists(memAddr) ? ramArr[memAddr] : 16'h0000;
    else
      memDqIn = 16'h5A3C;
  end

  // reference model
  typedef struct {
    bit rdy; bit ce; bit oe; bit we; bit drv; bit val;
    logic [18:0] addr; logic [15:0] data; string tag;
  } exp_t;
  exp_t expQ[$];
  logic [15:0] expMem [logic [18:0]];
  bit lastWr = 1'b0;
  bit checking = 1'b0;
  int checks = 0, failures = 0;
  int ceRun = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit rdy, bit ce, bit oe, bit we, bit drv, bit val,
                              logic [18:0] a, logic [15:0] d, string tag);
    exp_t e;
    e.rdy = rdy; e.ce = ce; e.oe = oe; e.we = we; e.drv = drv; e.val = val;
    e.addr = a; e.data = d; e.tag = tag;
    return e;
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      exp_t e;
      e = (expQ.size() > 0) ? expQ.pop_front() : mk(1, 1, 1, 1, 0, 0, '0, '0, "R9");
      chk(ready === e.rdy, "R2", "ready", ready, e.rdy);
      chk(memCeN === e.ce, e.tag, "ceN", memCeN, e.ce);
      chk(memOeN === e.oe, e.tag, "oeN", memOeN, e.oe);
      chk(memWeN === e.we, e.tag, "weN", memWeN, e.we);
      chk(memDqOe === e.drv, e.tag, "drive", memDqOe, e.drv);
      chk(!(memDqOe && !memOeN), "R3", "contention", memDqOe, 0);
      chk(rdValid === e.val, "R5", "rdValid", rdValid, e.val);
      if (!e.ce) chk(memAddr === e.addr, "R7", "address", memAddr, e.addr);
      if (e.drv) chk(memDqOut === e.data, "R7", "write data", memDqOut, e.data);
      if (e.val) chk(rdData === e.data, e.tag, "read data", rdData, e.data);
      if (memCeN === 1'b0) ceRun++;
      else if (ceRun > 0) begin
        chk(ceRun >= RC, "R8", "ce low cycles", ceRun, RC);
        ceRun = 0;
      end
    end
  end

  task automatic doOp(input bit wr, input logic [18:0] a, input logic [15:0] d,
                      input bit poke, input string rdTag);
    logic [15:0] rv;
    @(posedge clk);
    while (expQ.size() != 0) @(posedge clk);
    #1;
    expQ.push_back(mk(1, 1, 1, 1, 0, 0, a, d, "R9"));
    if (wr) begin
      expQ.push_back(mk(0, 0, 1, 1, 0, 0, a, d, "R4"));
      for (int i = 0; i < F; i++) expQ.push_back(mk(0, 0, 1, 0, 0, 0, a, d, "R4"));
      for (int i = 0; i < D; i++) expQ.push_back(mk(0, 0, 1, 0, 1, 0, a, d, "R4"));
      for (int i = 0; i < H; i++) expQ.push_back(mk(0, 0, 1, 1, 1, 0, a, d, "R4"));
      expMem[a] = d;
    end else begin
      rv = expMem.exists(a) ? expMem[a] : 16'h0000;
      if (lastWr)
        for (int i = 0; i < R; i++) expQ.push_back(mk(0, 0, 1, 1, 0, 0, a, d, "R6"));
      for (int i = 0; i < A; i++) expQ.push_back(mk(0, 0, 0, 1, 0, 0, a, d, "R5"));
      expQ.push_back(mk(1, 1, 1, 1, 0, 1, a, rv, rdTag));
    end
    lastWr = wr;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk); #1;
    if (poke) begin
      // request while busy: must be ignored (R2)
      reqWrite = 1'b1; reqAddr = 19'h00012; reqWdata = 16'hFFFF;
      @(posedge clk); #1;
    end
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(ready === 1'b1, "R1", "ready in reset", ready, 1);
    chk({memCeN, memOeN, memWeN} === 3'b111, "R1", "strobes in reset",
        {memCeN, memOeN, memWeN}, 3'b111);
    chk(memDqOe === 1'b0, "R1", "drive in reset", memDqOe, 0);
    chk(rdValid === 1'b0, "R1", "rdValid in reset", rdValid, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(ready === 1'b1 && memCeN === 1'b1, "R1", "after reset", {ready, memCeN}, 2'b11);
    checking = 1'b1;

    doOp(1, 19'h00012, 16'hA5A5, 0, "R5");
    doOp(0, 19'h00012, 16'h0000, 0, "R6");   // read after write waits recovery
    doOp(0, 19'h00012, 16'h0000, 0, "R5");   // plain read
    doOp(1, 19'h00340, 16'h1234, 1, "R2");   // busy request must not write
    doOp(0, 19'h00012, 16'h0000, 1, "R2");   // old value still there
    doOp(0, 19'h00777, 16'h0000, 0, "R5");   // never written -> 0
    doOp(1, 19'h7FFFF, 16'hFFFF, 0, "R4");
    doOp(1, 19'h00000, 16'h0000, 0, "R4");
    doOp(0, 19'h7FFFF, 16'h0000, 0, "R6");
    doOp(0, 19'h00000, 16'h0000, 0, "R5");
    doOp(0, 19'h00340, 16'h0000, 0, "R5");
    for (int k = 0; k < 8; k++) begin
      doOp(1, 19'(k * 4099), 16'(16'h0F0F ^ (k * 16'h1111)), 0, "R4");
      doOp(0, 19'(k * 4099), 16'h0000, 0, "R6");
    end
    repeat (6) @(posedge clk);
    #1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule